// File: doc/BRIEF.md
# Power Network Protection Rule Monitor

This block watches a small two-generator electrical distribution network and reports breaches of its protection rules. It sees three things: a health flag for each source (two AC generators and two rectifier units), the open or closed state of every contactor, and the powered flag that each bus reports. It drives none of these. Each clock it works out which buses have a live path (an unbroken chain of closed contactors) back to a healthy source. It then checks the observed state against five rules and records each broken rule in a sticky flag bit.

The network is fixed. Generator G0 feeds AC bus A0 through contactor k0, and G1 feeds AC bus A1 through k1. Contactor k2 ties A0 to A1. Rectifier U0 is fed from A0 through k3 and feeds DC bus D0 through k5. Rectifier U1 is fed from A1 through k4 and feeds D1 through k6. Contactor k7 ties D0 to D1.

The observed state is captured in a register first, and the rules are checked on that copy. A flag bit stays set until `clear` is pulsed, and `any_violation` summarises the whole flag vector. Which buses count as essential is set by a parameter.

Top module: `net_guard_mon`

## Requirements
- R1: Source health bit order is `src_ok[0]`=G0, `[1]`=G1, `[2]`=U0, `[3]`=U1, where 1 means healthy. Contactor bit i of `cont_closed` is contactor ki, where 1 means closed. A source whose health bit is 0 while any contactor touching it is closed sets `viol[0]`. The contactors touching each source are: G0 k0; G1 k1; U0 k3 and k5; U1 k4 and k6.
- R2: When k0, k1 and k2 are all closed, which is the only path between the two generators, `viol[1]` is set whatever the health flags are.
- R3: Bus order in `bus_pwr` is `[0]`=A0, `[1]`=A1, `[2]`=D0, `[3]`=D1. A bus reported as 0 that does have a live path to a healthy source sets `viol[2]`.
- R4: A bus reported as 1 that has no live path to a healthy source sets `viol[3]`.
- R5: Any bus selected by `ESS_MASK` (default: A0 only) that is reported as 0 sets `viol[4]`, whether or not it has a live path.
- R6: AC bus Ai is live if Gi is healthy with ki closed, or if the other generator is healthy with its own contactor and k2 closed. DC bus Di is fed through its own rectifier when that rectifier is healthy, both of its contactors are closed and its upstream AC bus is live. It is also fed through k7 from the other side's feed.
- R7: Flag bits are sticky. A cycle with `clear` high drops the bits already held, but a rule broken by the state in the pipeline during that cycle is still recorded.
- R8: `any_violation` is 1 exactly when at least one bit of `viol` is 1.
- R9: An offending state held across one rising edge is captured at that edge. Its flag appears at the next rising edge and not before.
- R10: During and right after reset, `viol` is zero and `any_violation` is 0. The state captured during reset never raises a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Drops held flag bits |
| src_ok | input | 4 | Source health, 1 = healthy |
| cont_closed | input | 8 | Contactor state, 1 = closed |
| bus_pwr | input | 4 | Reported bus powered flags |
| viol | output | 5 | Sticky flags: isolation, paralleling, missed power, false power, essential loss |
| any_violation | output | 1 | OR of all flag bits |

## Verification
The bench targets three groups of cases.

The first is bus power that reaches a bus only indirectly. An AC bus fed across the tie from the far generator must not raise a false-power flag. A DC bus fed across the DC tie from the other rectifier must not either. A design that ignored the tie paths would flag both as false power. A design that did not require a live upstream AC bus would miss the dead DC bus behind a failed generator.

The second is a failed generator that is correctly isolated while a bus stays live through the tie. Only a design that checks isolation against the adjacency of each source keeps this case clean.

The third is timing. The bench checks the one-cycle delay before a flag appears, that flags persist after the state returns to safe, and that a clear issued while a breach is still present does not hide that breach. It also checks that the zeroed state captured during reset raises no false essential-bus flag.

// File: rtl/net_mon_pkg.sv
package net_mon_pkg;

    localparam int N_SRC  = 4;
    localparam int N_CONT = 8;
    localparam int N_BUS  = 4;
    localparam int N_RULE = 5;
    localparam int N_SIDE = 2;

    localparam int K_TIE_AC = 2;
    localparam int K_TIE_DC = 7;
    localparam int SRC_RECT0 = 2;
    localparam int K_AC_RECT0 = 3;
    localparam int K_RECT_DC0 = 5;
    localparam int BUS_DC0 = 2;

    localparam int RULE_ISO  = 0;
    localparam int RULE_PARA = 1;
    localparam int RULE_MISS = 2;
    localparam int RULE_FAKE = 3;
    localparam int RULE_ESS  = 4;

    typedef struct packed {
        logic [N_SRC-1:0]  src;
        logic [N_CONT-1:0] cont;
        logic [N_BUS-1:0]  pwr;
    } obs_t;

    // Contactors that touch each source.
    function automatic logic [N_CONT-1:0] adj_mask(input int idx);
        logic [N_CONT-1:0] m;
        m = '0;
        if (idx < N_SIDE) begin
            m[idx] = 1'b1;
        end else begin
            m[K_AC_RECT0 + idx - SRC_RECT0] = 1'b1;
            m[K_RECT_DC0 + idx - SRC_RECT0] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/net_live_eval.sv
module net_live_eval
    import net_mon_pkg::*;
(
    input  logic [N_SRC-1:0]  src,
    input  logic [N_CONT-1:0] cont,
    output logic [N_BUS-1:0]  live,
    output logic              gen_parallel
);
    logic [N_SIDE-1:0] ac_live;
    logic [N_SIDE-1:0] own_feed;
    logic [N_SIDE-1:0] rect_feed;

    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
        localparam int O = N_SIDE - 1 - s;
        assign own_feed[s] = src[s] & cont[s];
        assign ac_live[s]  = own_feed[s] | (src[O] & cont[O] & cont[K_TIE_AC]);
        assign rect_feed[s] = src[SRC_RECT0 + s] & cont[K_AC_RECT0 + s]
                            & cont[K_RECT_DC0 + s] & ac_live[s];
        assign live[s] = ac_live[s];
        assign live[BUS_DC0 + s] = rect_feed[s] | (rect_feed[O] & cont[K_TIE_DC]);
    end

    assign gen_parallel = cont[0] & cont[1] & cont[K_TIE_AC];

endmodule

// File: rtl/net_rule_eval.sv
module net_rule_eval
    import net_mon_pkg::*;
#(
    parameter logic [N_BUS-1:0] ESS_MASK = 4'b0001
) (
    input  obs_t              obs,
    input  logic [N_BUS-1:0]  live,
    input  logic              gen_parallel,
    output logic [N_RULE-1:0] hit
);
    logic [N_SRC-1:0] iso_bad;

    for (genvar i = 0; i < N_SRC; i++) begin : g_iso
        assign iso_bad[i] = !obs.src[i] && |(obs.cont & adj_mask(i));
    end

    always_comb begin
        hit            = '0;
        hit[RULE_ISO]  = |iso_bad;
        hit[RULE_PARA] = gen_parallel;
        hit[RULE_MISS] = |(live & ~obs.pwr);
        hit[RULE_FAKE] = |(~live & obs.pwr);
        hit[RULE_ESS]  = |(ESS_MASK & ~obs.pwr);
    end

endmodule

// File: rtl/net_guard_mon.sv
module net_guard_mon
    import net_mon_pkg::*;
#(
    parameter logic [N_BUS-1:0] ESS_MASK = 4'b0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [N_SRC-1:0]  src_ok,
    input  logic [N_CONT-1:0] cont_closed,
    input  logic [N_BUS-1:0]  bus_pwr,
    output logic [N_RULE-1:0] viol,
    output logic              any_violation
);
    typedef struct packed {
        logic              valid;
        obs_t              obs;
        logic [N_RULE-1:0] viol;
    } mon_state_t;

    mon_state_t st_d, st_q;
    logic [N_BUS-1:0]  live;
    logic              gen_parallel;
    logic [N_RULE-1:0] raw_hit;
    logic [N_RULE-1:0] hit;

    net_live_eval u_live (
        .src          (st_q.obs.src),
        .cont         (st_q.obs.cont),
        .live         (live),
        .gen_parallel (gen_parallel)
    );

    net_rule_eval #(.ESS_MASK(ESS_MASK)) u_rules (
        .obs          (st_q.obs),
        .live         (live),
        .gen_parallel (gen_parallel),
        .hit          (raw_hit)
    );

    assign hit = st_q.valid ? raw_hit : '0;

    always_comb begin
        st_d          = st_q;
        st_d.valid    = 1'b1;
        st_d.obs.src  = src_ok;
        st_d.obs.cont = cont_closed;
        st_d.obs.pwr  = bus_pwr;
        st_d.viol     = (clear ? '0 : st_q.viol) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign viol          = st_q.viol;
    assign any_violation = |st_q.viol;

    p_iso_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !st_q.obs.src[0] && st_q.obs.cont[0]) |=> viol[RULE_ISO]);

    p_para_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && st_q.obs.cont[0] && st_q.obs.cont[1] && st_q.obs.cont[K_TIE_AC])
        |=> viol[RULE_PARA]);

    p_ess_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && ((st_q.obs.pwr & ESS_MASK) != ESS_MASK)) |=> viol[RULE_ESS]);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((viol & $past(viol)) == $past(viol)));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && (hit == '0)) |=> (viol == '0));

endmodule

// File: tb/net_guard_mon_tb.sv
`timescale 1ns/1ps
module net_guard_mon_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic [3:0] src_ok = 4'hF;
    logic [7:0] cont_closed = 8'h7B;
    logic [3:0] bus_pwr = 4'hF;
    logic [4:0] viol;
    logic       any_violation;

    int n_tests = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    net_guard_mon u_dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .src_ok(src_ok),
        .cont_closed(cont_closed), .bus_pwr(bus_pwr),
        .viol(viol), .any_violation(any_violation)
    );

    // {src_ok, cont_closed, bus_pwr, expected viol}
    localparam int NV = 11;
    localparam logic [20:0] VEC [NV] = '{
        {4'hF, 8'h7B, 4'hF, 5'b00000},  // all healthy, normal line-up
        {4'hE, 8'h7B, 4'hF, 5'b01001},  // G0 failed but still connected
        {4'hE, 8'h7E, 4'hF, 5'b00000},  // G0 isolated, A0 fed over tie
        {4'hF, 8'h7F, 4'hF, 5'b00010},  // generators paralleled
        {4'hF, 8'h7B, 4'hD, 5'b00100},  // A1 reported off while live
        {4'hF, 8'h7A, 4'hA, 5'b10000},  // essential A0 truly dead
        {4'hB, 8'h7B, 4'hF, 5'b01001},  // U0 failed still connected
        {4'hB, 8'hD3, 4'hF, 5'b00000},  // U0 isolated, D0 over DC tie
        {4'hD, 8'h79, 4'hF, 5'b01000},  // A1 dead so D1 dead, reported on
        {4'hD, 8'h79, 4'h5, 5'b00000},  // same, reported correctly
        {4'hE, 8'h7F, 4'h0, 5'b10111}   // several at once
    };

    function automatic string tag_of(input logic [4:0] e);
        if (e[0]) return "R1";
        if (e[1]) return "R2";
        if (e[2]) return "R3";
        if (e[3]) return "R4";
        if (e[4]) return "R5";
        return "R6";
    endfunction

    task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: viol=%b expected %b", tag, got, exp);
        end
        n_tests++;
        if (any_violation !== (|exp)) begin
            n_fail++;
            $display("FAIL R8 (%s): any_violation=%b expected %b", tag, any_violation, |exp);
        end
    endtask

    task automatic drive(input logic [3:0] s, input logic [7:0] c, input logic [3:0] p);
        src_ok = s;
        cont_closed = c;
        bus_pwr = p;
    endtask

    task automatic settle_and_clear();
        drive(4'hF, 8'h7B, 4'hF);
        repeat (2) @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R10: reset with an all-zero captured state must stay clean
        drive(4'h0, 8'h00, 4'h0);
        repeat (3) @(negedge clk);
        check("R10 in reset", viol, 5'b00000);
        drive(4'hF, 8'h7B, 4'hF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset", viol, 5'b00000);
        repeat (2) @(negedge clk);
        check("R10 settled", viol, 5'b00000);

        for (int i = 0; i < NV; i++) begin
            settle_and_clear();
            drive(VEC[i][20:17], VEC[i][16:9], VEC[i][8:5]);
            repeat (2) @(negedge clk);
            check(tag_of(VEC[i][4:0]), viol, VEC[i][4:0]);
        end

        // R9: flag is not visible after one edge, visible after two
        settle_and_clear();
        drive(4'hE, 8'h7B, 4'hF);
        @(negedge clk);
        check("R9 early", viol, 5'b00000);
        @(negedge clk);
        check("R9 on time", viol, 5'b01001);

        // R7: flags persist after return to a safe state
        settle_and_clear();
        drive(4'hF, 8'h7F, 4'hF);
        repeat (2) @(negedge clk);
        drive(4'hF, 8'h7B, 4'hF);
        repeat (4) @(negedge clk);
        check("R7 sticky", viol, 5'b00010);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        check("R7 cleared", viol, 5'b00000);

        // R7: clear during an ongoing breach keeps it recorded
        drive(4'hF, 8'h7F, 4'hF);
        repeat (2) @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        check("R7 clear vs live breach", viol, 5'b00010);

        // R6: DC tie cannot rescue D1 when both feeds are dead
        settle_and_clear();
        drive(4'h3, 8'h9B, 4'h3);
        repeat (2) @(negedge clk);
        check("R6 dead DC pair", viol, 5'b00001);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule